// File: doc/BRIEF.md
# Condition Field Register with Compare and Branch Resolve

This block keeps a 32-bit condition register made of eight 4-bit fields. In a cycle where a compare is requested, a comparator orders a left operand against either a second operand or a 16-bit immediate. The comparison is signed or unsigned, as selected. The resulting less/greater/equal flags, together with a copy of a summary-overflow input, are written into the one field chosen by a field index. All other fields keep their contents.

Alongside the register, a branch resolver tests one bit of field 0 against a required value, or takes the branch without condition. It raises a taken flag and picks the next program counter: the branch target when taken, otherwise the sequential address. When a compare writes field 0 in the same cycle that a branch is resolved, the resolver sees the new field value. This lets a compare and its dependent branch issue back to back without a stall.

Top module: `crf_cmp_branch`

## Requirements
- R1: While reset is asserted, and in every cycle after it until the first compare, `cr_q` is all zeros.
- R2: A compare with `cmp_unsigned`=0 and `cmp_use_imm`=0 orders `cmp_opa` against `cmp_opb` as two's-complement numbers. The written 4-bit field is {LT,GT,EQ,SO}, with LT in the field's bit 3 and SO in bit 0, and exactly one of LT, GT and EQ is set.
- R3: With `cmp_unsigned`=1 the operands are ordered as unsigned numbers.
- R4: With `cmp_use_imm`=1 and `cmp_unsigned`=0 the right operand is `cmp_imm` sign-extended to 32 bits.
- R5: With `cmp_use_imm`=1 and `cmp_unsigned`=1 the right operand is `cmp_imm` zero-extended to 32 bits.
- R6: Field k occupies `cr_q[31-4k:28-4k]`, so field 0 is the top nibble. A compare changes only the field named by `cmp_field`, one clock edge after `cmp_valid`.
- R7: The SO bit of the written field takes the value of `so_in` in the compare cycle.
- R8: With `cmp_valid`=0, `cr_q` holds its value whatever the operand inputs do.
- R9: `br_cond` is {uncond, sense, sel[1:0]}, where sel 0/1/2/3 picks LT/GT/EQ/SO of field 0. `br_taken` is 1 exactly when `br_valid`=1 and either uncond=1 or the selected bit equals sense. With `br_valid`=0, `br_taken` is 0.
- R10: If a compare writes field 0 in the cycle a branch is resolved, the branch is resolved against the newly computed field. A compare to any other field leaves the branch resolving against the current field 0.
- R11: `next_pc` equals `br_target` when `br_taken` is 1 and `pc_seq` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_valid | input | 1 | Perform a compare this cycle |
| cmp_unsigned | input | 1 | 1 = unsigned ordering, 0 = signed |
| cmp_use_imm | input | 1 | 1 = compare against the immediate |
| cmp_field | input | 3 | Index of the field to write |
| cmp_opa | input | 32 | Left operand |
| cmp_opb | input | 32 | Right operand (register form) |
| cmp_imm | input | 16 | Immediate right operand |
| so_in | input | 1 | Summary-overflow value copied into the written field |
| br_valid | input | 1 | A branch is being resolved |
| br_cond | input | 4 | Branch condition {uncond, sense, sel[1:0]} |
| pc_seq | input | 32 | Sequential next address |
| br_target | input | 32 | Branch target address |
| cr_q | output | 32 | Condition register contents |
| br_taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Chosen next program counter |

## Verification
The comparator is exercised with operand pairs whose signed and unsigned order differ, such as all-ones against one and the most negative value against the most positive. This separates the two orderings and exposes a missing sign flip. Equal operands and immediates with bit 15 set distinguish sign extension from zero extension. Fields 0 and 7 are written with SO both set and clear, which pins down the nibble placement and the bit order inside a field. Each branch condition is then resolved against field 0 in each of its three states. A same-cycle compare to field 0 is contrasted with one to field 3 to show the bypass applies only to the field the branch reads.

// File: rtl/crf_pkg.sv
package crf_pkg;

  localparam int unsigned FLD_W = 4;

  // bit selector inside a field
  typedef enum logic [1:0] {
    CRB_LT = 2'd0,
    CRB_GT = 2'd1,
    CRB_EQ = 2'd2,
    CRB_SO = 2'd3
  } crb_sel_e;

  // one field; lt is the most significant bit
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_field_t;

  typedef struct packed {
    logic     uncond;
    logic     sense;
    crb_sel_e sel;
  } br_cond_t;

endpackage

// File: rtl/crf_compare.sv
module crf_compare
  import crf_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned IMM_W  = 16,
  localparam int unsigned EXT_W  = DATA_W - IMM_W
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              is_unsigned,
  input  logic              so_in,
  output crf_field_t        res
);

  logic [DATA_W-1:0] rhs;
  logic [DATA_W-1:0] lhs_key;
  logic [DATA_W-1:0] rhs_key;
  logic              flip;

  always_comb begin
    if (!use_imm) begin
      rhs = opb;
    end else if (is_unsigned) begin
      rhs = {{EXT_W{1'b0}}, imm};
    end else begin
      rhs = {{EXT_W{imm[IMM_W-1]}}, imm};
    end
  end

  // inverting the sign bits maps signed order onto unsigned order
  assign flip    = ~is_unsigned;
  assign lhs_key = {opa[DATA_W-1] ^ flip, opa[DATA_W-2:0]};
  assign rhs_key = {rhs[DATA_W-1] ^ flip, rhs[DATA_W-2:0]};

  always_comb begin
    res.lt = (lhs_key < rhs_key);
    res.eq = (opa == rhs);
    res.gt = ~res.lt & ~res.eq;
    res.so = so_in;
  end

endmodule

// File: rtl/crf_field_bank.sv
module crf_field_bank
  import crf_pkg::*;
#(
  parameter  int unsigned NUM_FLD = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_FLD),
  localparam int unsigned CR_W    = NUM_FLD * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  crf_field_t       wr_val,
  output logic [CR_W-1:0]  cr_q,
  output crf_field_t       lead_next
);

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    logic       en;
    crf_field_t nxt;
    crf_field_t cur;

    always_comb begin
      en  = wr_en && (wr_idx == IDX_W'(g));
      nxt = en ? wr_val : cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur <= '0;
      end else if (en) begin
        cur <= nxt;
      end
    end

    // field 0 sits in the top nibble
    assign cr_q[CR_W-1-FLD_W*g -: FLD_W] = cur;
  end

  assign lead_next = g_fld[0].nxt;

endmodule

// File: rtl/crf_branch_eval.sv
module crf_branch_eval
  import crf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              br_valid,
  input  br_cond_t          cond,
  input  crf_field_t        fld,
  input  logic [ADDR_W-1:0] pc_seq,
  input  logic [ADDR_W-1:0] target,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);

  logic bit_v;
  logic hit;

  always_comb begin
    case (cond.sel)
      CRB_LT:  bit_v = fld.lt;
      CRB_GT:  bit_v = fld.gt;
      CRB_EQ:  bit_v = fld.eq;
      default: bit_v = fld.so;
    endcase
    hit     = cond.uncond | (bit_v == cond.sense);
    taken   = br_valid & hit;
    next_pc = taken ? target : pc_seq;
  end

endmodule

// File: rtl/crf_cmp_branch.sv
module crf_cmp_branch
  import crf_pkg::*;
#(
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned IMM_W   = 16,
  parameter  int unsigned NUM_FLD = 8,
  parameter  int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_FLD),
  localparam int unsigned CR_W    = NUM_FLD * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_unsigned,
  input  logic              cmp_use_imm,
  input  logic [IDX_W-1:0]  cmp_field,
  input  logic [DATA_W-1:0] cmp_opa,
  input  logic [DATA_W-1:0] cmp_opb,
  input  logic [IMM_W-1:0]  cmp_imm,
  input  logic              so_in,
  input  logic              br_valid,
  input  logic [3:0]        br_cond,
  input  logic [ADDR_W-1:0] pc_seq,
  input  logic [ADDR_W-1:0] br_target,
  output logic [CR_W-1:0]   cr_q,
  output logic              br_taken,
  output logic [ADDR_W-1:0] next_pc
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  crf_field_t cmp_res;
  crf_field_t lead_next;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  crf_compare #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_cmp (
    .opa         (cmp_opa),
    .opb         (cmp_opb),
    .imm         (cmp_imm),
    .use_imm     (cmp_use_imm),
    .is_unsigned (cmp_unsigned),
    .so_in       (so_in),
    .res         (cmp_res)
  );

  crf_field_bank #(
    .NUM_FLD (NUM_FLD)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (cmp_valid),
    .wr_idx    (cmp_field),
    .wr_val    (cmp_res),
    .cr_q      (cr_q),
    .lead_next (lead_next)
  );

  crf_branch_eval #(
    .ADDR_W (ADDR_W)
  ) u_br (
    .br_valid (br_valid),
    .cond     (br_cond_t'(br_cond)),
    .fld      (lead_next),
    .pc_seq   (pc_seq),
    .target   (br_target),
    .taken    (br_taken),
    .next_pc  (next_pc)
  );

endmodule

// File: rtl/crf_cmp_branch_chk.sv
module crf_cmp_branch_chk #(
  parameter  int unsigned NUM_FLD = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_FLD),
  localparam int unsigned CR_W    = NUM_FLD * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic [IDX_W-1:0] cmp_field,
  input logic             so_in,
  input logic             br_valid,
  input logic [3:0]       br_cond,
  input logic             br_taken,
  input logic [CR_W-1:0]  cr_q
);

  logic [IDX_W-1:0] fld_q;
  logic             so_q;
  logic [CR_W-1:0]  wmask;
  logic [3:0]       wr_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      so_q  <= 1'b0;
    end else begin
      fld_q <= cmp_field;
      so_q  <= so_in;
    end
  end

  always_comb begin
    wmask  = '0;
    wr_nib = '0;
    for (int i = 0; i < NUM_FLD; i++) begin
      if (cmp_field == IDX_W'(i)) wmask[CR_W-1-4*i -: 4] = 4'hF;
      if (fld_q == IDX_W'(i))     wr_nib = cr_q[CR_W-1-4*i -: 4];
    end
  end

  a_r2_single_relation: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> $countones(wr_nib[3:1]) == 1);

  a_r7_so_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> wr_nib[0] == so_q);

  a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> ((cr_q ^ $past(cr_q)) & ~$past(wmask)) == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(cr_q));

  a_r9_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !br_taken);

  a_r9_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond[3]) |-> br_taken);

endmodule

bind crf_cmp_branch crf_cmp_branch_chk #(
  .NUM_FLD (NUM_FLD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_field (cmp_field),
  .so_in     (so_in),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .br_taken  (br_taken),
  .cr_q      (cr_q)
);

// File: tb/crf_cmp_branch_tb.sv
module crf_cmp_branch_tb;

  logic        clk;
  logic        rst_n;
  logic        cmp_valid, cmp_unsigned, cmp_use_imm, so_in;
  logic [2:0]  cmp_field;
  logic [31:0] cmp_opa, cmp_opb, pc_seq, br_target;
  logic [15:0] cmp_imm;
  logic        br_valid;
  logic [3:0]  br_cond;
  logic [31:0] cr_q, next_pc;
  logic        br_taken;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_cr;
  bit done = 0;

  crf_cmp_branch u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_unsigned(cmp_unsigned),
    .cmp_use_imm(cmp_use_imm), .cmp_field(cmp_field), .cmp_opa(cmp_opa),
    .cmp_opb(cmp_opb), .cmp_imm(cmp_imm), .so_in(so_in), .br_valid(br_valid),
    .br_cond(br_cond), .pc_seq(pc_seq), .br_target(br_target), .cr_q(cr_q),
    .br_taken(br_taken), .next_pc(next_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_field(input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] imm, input logic use_imm, input logic uns, input logic so);
    logic [31:0] r;
    logic lt, gt, eq;
    r  = use_imm ? (uns ? {16'h0, imm} : {{16{imm[15]}}, imm}) : b;
    eq = (a == r);
    if (uns) begin lt = a < r; gt = a > r; end
    else begin lt = $signed(a) < $signed(r); gt = $signed(a) > $signed(r); end
    return {lt, gt, eq, so};
  endfunction

  // apply one compare at a negative edge, clock it, check whole register
  task automatic do_cmp(input string req, input logic [2:0] idx, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic use_imm,
      input logic uns, input logic so);
    cmp_valid = 1; cmp_field = idx; cmp_opa = a; cmp_opb = b; cmp_imm = imm;
    cmp_use_imm = use_imm; cmp_unsigned = uns; so_in = so;
    model_cr[31-4*idx -: 4] = exp_field(a, b, imm, use_imm, uns, so);
    @(posedge clk); @(negedge clk);
    cmp_valid = 0;
    check(req, cr_q, model_cr);
  endtask

  task automatic do_branch(input string req, input logic valid, input logic [3:0] cond,
      input logic exp_taken);
    br_valid = valid; br_cond = cond; pc_seq = 32'h0000_0104; br_target = 32'h0000_2000;
    #2;
    check({req, " taken"}, {31'h0, br_taken}, {31'h0, exp_taken});
    check("R11 next_pc", next_pc, exp_taken ? 32'h0000_2000 : 32'h0000_0104);
    br_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset value", cr_q, 32'h0);
  endtask

  task automatic t_signed;
    do_cmp("R2 signed less", 3'd1, 32'd5, 32'd9, 16'h0, 0, 0, 0);
    do_cmp("R2 signed greater", 3'd2, 32'd9, 32'd5, 16'h0, 0, 0, 0);
    do_cmp("R2 signed equal", 3'd3, 32'd7, 32'd7, 16'h0, 0, 0, 0);
    do_cmp("R2 signed minus one", 3'd4, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 0);
    check("R2 nibble LT", {28'h0, cr_q[15:12]}, 32'h8);
    do_cmp("R2 signed extremes", 3'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 0);
  endtask

  task automatic t_unsigned;
    do_cmp("R3 unsigned minus one", 3'd4, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 1, 0);
    check("R3 nibble GT", {28'h0, cr_q[15:12]}, 32'h4);
    do_cmp("R3 unsigned extremes", 3'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 1, 0);
    do_cmp("R3 unsigned small", 3'd6, 32'd1, 32'hFFFF_FFFF, 16'h0, 0, 1, 0);
  endtask

  task automatic t_imm;
    do_cmp("R4 sext equal", 3'd2, 32'hFFFF_FFFE, 32'h0, 16'hFFFE, 1, 0, 0);
    check("R4 nibble EQ", {28'h0, cr_q[23:20]}, 32'h2);
    do_cmp("R4 sext negative imm", 3'd3, 32'd5, 32'h0, 16'h8000, 1, 0, 0);
    do_cmp("R5 zext equal", 3'd2, 32'h0000_FFFE, 32'h0, 16'hFFFE, 1, 1, 0);
    check("R5 nibble EQ", {28'h0, cr_q[23:20]}, 32'h2);
    do_cmp("R5 zext high imm", 3'd3, 32'd5, 32'h0, 16'h8000, 1, 1, 0);
  endtask

  task automatic t_fields;
    do_cmp("R6 field0 write", 3'd0, 32'd3, 32'd3, 16'h0, 0, 0, 1);
    check("R6 field0 top nibble", {28'h0, cr_q[31:28]}, 32'h3);
    do_cmp("R6 field7 write", 3'd7, 32'd1, 32'd2, 16'h0, 0, 0, 1);
    check("R7 field7 so set", {28'h0, cr_q[3:0]}, 32'h9);
    do_cmp("R7 field7 so clear", 3'd7, 32'd1, 32'd2, 16'h0, 0, 0, 0);
    check("R7 field7 nibble", {28'h0, cr_q[3:0]}, 32'h8);
  endtask

  task automatic t_hold;
    cmp_valid = 0; cmp_field = 3'd1; cmp_opa = 32'd100; cmp_opb = 32'd1; so_in = 1;
    repeat (3) @(negedge clk);
    check("R8 idle hold", cr_q, model_cr);
  endtask

  task automatic t_branch;
    // field0 = LT
    do_cmp("R9 setup lt", 3'd0, 32'd1, 32'd2, 16'h0, 0, 0, 0);
    do_branch("R9 blt on lt", 1, 4'b0100, 1);
    do_branch("R9 bgt on lt", 1, 4'b0101, 0);
    do_branch("R9 ble on lt", 1, 4'b0001, 1);
    do_branch("R9 no valid", 0, 4'b1000, 0);
    // field0 = GT
    do_cmp("R9 setup gt", 3'd0, 32'd9, 32'd2, 16'h0, 0, 0, 1);
    do_branch("R9 bgt on gt", 1, 4'b0101, 1);
    do_branch("R9 ble on gt", 1, 4'b0001, 0);
    do_branch("R9 so set test", 1, 4'b0111, 1);
    // field0 = EQ
    do_cmp("R9 setup eq", 3'd0, 32'd4, 32'd4, 16'h0, 0, 0, 0);
    do_branch("R9 beq on eq", 1, 4'b0110, 1);
    do_branch("R9 blt on eq", 1, 4'b0100, 0);
    do_branch("R9 always", 1, 4'b1100, 1);
  endtask

  task automatic t_bypass;
    // field0 is EQ now; same-cycle compare to field0 makes it LT
    cmp_valid = 1; cmp_field = 3'd0; cmp_opa = 32'd1; cmp_opb = 32'd8;
    cmp_use_imm = 0; cmp_unsigned = 0; so_in = 0;
    br_valid = 1; br_cond = 4'b0100; pc_seq = 32'h0000_0104; br_target = 32'h0000_2000;
    #2;
    check("R10 bypass field0 taken", {31'h0, br_taken}, 32'h1);
    check("R10 bypass next_pc", next_pc, 32'h0000_2000);
    model_cr[31:28] = 4'h8;
    @(posedge clk); @(negedge clk);
    // compare to field3 must not affect branch on field0 (LT now)
    cmp_field = 3'd3; cmp_opa = 32'd9; cmp_opb = 32'd1; br_cond = 4'b0101;
    #2;
    check("R10 other field no bypass", {31'h0, br_taken}, 32'h0);
    model_cr[19:16] = 4'h4;
    @(posedge clk); @(negedge clk);
    cmp_valid = 0; br_valid = 0;
    check("R10 register after", cr_q, model_cr);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmp_valid = 0; cmp_unsigned = 0; cmp_use_imm = 0; cmp_field = 0;
    cmp_opa = 0; cmp_opb = 0; cmp_imm = 0; so_in = 0; br_valid = 0; br_cond = 0;
    pc_seq = 0; br_target = 0; model_cr = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", cr_q, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_imm();
    t_fields();
    t_hold();
    t_branch();
    t_bypass();
    rst_n = 0;
    #3;
    check("R1 async clear", cr_q, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule